// File: doc/BRIEF.md
# Debounced Multichannel Interrupt Capture Unit

This block takes one comparator output per input channel and turns them into interrupt outputs. Each channel is synchronized to the system clock. It then passes through a per-channel polarity select and a debounce filter. The debounce filter forwards the channel only after its active condition has held without a break for longer than a programmed number of clock cycles, so short transients are dropped. Each debounced channel is then gated by a mask bit. All surviving channels are ORed into a single interrupt source.

The interrupt source drives two outputs. One is a level output that stays set until the host clears it. The other is a request pulse of a fixed number of clock cycles, which fires on each rising edge of the source. The unit also records which channel qualified first, so the host can identify the cause of the interrupt. A small register port lets the host set the debounce time, the inversion bits and the mask, read all of them back, read the first-channel record and clear the latched state.

Top module: `irq_capture_top`

## Requirements
- R1: A channel qualifies only after its synchronized active condition has been sampled on DEB_TIME+1 consecutive clock edges. An excursion of DEB_TIME cycles or fewer raises nothing. If a channel input changes just after clock edge n, the level output and the first-channel record update after edge n+DEB_TIME+4.
- R2: A single inactive sample restarts a channel's debounce count from zero, so broken runs do not add up.
- R3: If a channel's inversion bit is 0, the channel is active when its input is low. If the bit is 1, the channel is active when its input is high.
- R4: A mask bit of 1 blocks its channel from the level output, the pulse and the first-channel record. After reset, every mask bit is 1.
- R5: `irq_level` is set by any debounced, unmasked channel and stays set until a clear.
- R6: `irq_pulse` goes high for exactly PULSE_CYC cycles. It starts in the same cycle as the level output, and only on a rising edge of the ORed source. A rising edge that arrives while a pulse is running is ignored.
- R7: Reading address 3 returns the first-channel record: bit REG_W-1 is the valid flag, and the low bits hold the channel index. Once the record is valid, channels that qualify later leave it unchanged.
- R8: If several channels qualify in the same cycle, the lowest-numbered one is recorded.
- R9: A write to address 3 clears the level output and the first-channel record at that edge, and the clear wins over a source that is active in the same cycle. If the source is still active, both are set again on the next edge, and no new pulse is started.
- R10: Address 0 holds the debounce time, address 1 the inversion bits and address 2 the mask. Writes take effect at the clock edge, and reads return the stored value. After reset, the debounce time and the inversion bits are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | NCH | Comparator outputs, one per channel, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | REG_W | Read data for rd_addr, combinational |
| irq_level | output | 1 | Latched interrupt level |
| irq_pulse | output | 1 | Fixed-width interrupt request pulse |

## Verification
The bench builds the unit with 16 channels, a 16-bit debounce register, 16-bit register words and a 25-cycle pulse, which is the full-size configuration. Because the debounce time is programmed at run time, setting it to 0 and to 3 covers the exact boundary between rejection and acceptance, a broken run, and the zero-delay path, all within a few dozen cycles. Using all 16 channels brings the top valid bit and the index field into play together, along with same-cycle priority between channels 10 and 12.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

    // Register map selector
    typedef enum logic [1:0] {
        REG_DEB   = 2'd0,
        REG_INV   = 2'd1,
        REG_MASK  = 2'd2,
        REG_FIRST = 2'd3
    } reg_sel_e;

    // Widest channel index the record can hold (up to 256 channels)
    localparam int MAX_IDX_W = 8;

    typedef struct packed {
        logic                 valid;
        logic [MAX_IDX_W-1:0] idx;
    } first_rec_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irq_chan_filter.sv
module irq_chan_filter #(
    parameter int DB_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sig_s,
    input  logic            inv,
    input  logic [DB_W-1:0] deb_time,
    output logic            deb
);
    logic            act;
    logic [DB_W-1:0] cnt;

    assign act = inv ? sig_s : ~sig_s;

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            cnt <= '0;
            deb <= 1'b0;
        end else if (cnt < deb_time) begin
            cnt <= cnt + 1'b1;
            deb <= 1'b0;
        end else begin
            deb <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
    parameter int CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    output logic pulse
);
    localparam int CNT_W = $clog2(CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            src_q <= 1'b0;
        end else begin
            src_q <= src;
            if (cnt != '0)
                cnt <= cnt - 1'b1;
            else if (src && !src_q)
                cnt <= CNT_W'(CYC);
        end
    end

    assign pulse = (cnt != '0);
endmodule

// File: rtl/irq_capture_top.sv
module irq_capture_top
    import irq_cap_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int DB_W      = 16,
    parameter int REG_W     = 16,
    parameter int PULSE_CYC = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   comp_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_level,
    output logic             irq_pulse
);
    localparam int IDX_W = idx_width(NCH);

    logic [DB_W-1:0]      deb_q;
    logic [NCH-1:0]       inv_q;
    logic [NCH-1:0]       mask_q;
    logic [NCH-1:0]       comp_s;
    logic [NCH-1:0]       deb_vec;
    logic [NCH-1:0]       hit;
    logic                 src;
    logic [IDX_W-1:0]     low_idx;
    logic                 clr;
    first_rec_t           first_q;
    logic                 first_vld;
    logic [MAX_IDX_W-1:0] first_idx;

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            deb_q  <= '0;
            inv_q  <= '0;
            mask_q <= '1;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_DEB:  deb_q  <= wr_data[DB_W-1:0];
                REG_INV:  inv_q  <= wr_data[NCH-1:0];
                REG_MASK: mask_q <= wr_data[NCH-1:0];
                default:  ;
            endcase
        end
    end

    assign clr = wr_en && (reg_sel_e'(wr_addr) == REG_FIRST);

    irq_sync2 #(.W(NCH)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (comp_in),
        .q   (comp_s)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        irq_chan_filter #(.DB_W(DB_W)) filt_i (
            .clk      (clk),
            .rst      (rst),
            .sig_s    (comp_s[g]),
            .inv      (inv_q[g]),
            .deb_time (deb_q),
            .deb      (deb_vec[g])
        );
    end

    // Source and lowest-index priority
    always_comb begin
        hit     = deb_vec & ~mask_q;
        src     = |hit;
        low_idx = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (hit[i]) low_idx = IDX_W'(i);
    end

    // Latched level and first-channel record
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            irq_level <= 1'b0;
            first_q   <= '0;
        end else begin
            if (src) irq_level <= 1'b1;
            if (src && !first_q.valid) begin
                first_q.valid <= 1'b1;
                first_q.idx   <= MAX_IDX_W'(low_idx);
            end
        end
    end

    assign first_vld = first_q.valid;
    assign first_idx = first_q.idx;

    irq_pulse_gen #(.CYC(PULSE_CYC)) pgen_i (
        .clk   (clk),
        .rst   (rst),
        .src   (src),
        .pulse (irq_pulse)
    );

    // Read mux
    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            REG_DEB:  rd_data[DB_W-1:0] = deb_q;
            REG_INV:  rd_data[NCH-1:0]  = inv_q;
            REG_MASK: rd_data[NCH-1:0]  = mask_q;
            default: begin
                rd_data[REG_W-1]       = first_vld;
                rd_data[MAX_IDX_W-1:0] = first_idx;
            end
        endcase
    end
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
    parameter int NCH       = 16,
    parameter int PULSE_CYC = 25
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic [1:0]                      wr_addr,
    input logic                            irq_level,
    input logic                            irq_pulse,
    input logic                            first_vld,
    input logic [irq_cap_pkg::MAX_IDX_W-1:0] first_idx,
    input logic [NCH-1:0]                  mask_q
);
    logic           clr_w;
    logic [31:0]    run;
    logic [NCH-1:0] one_v;

    assign clr_w = wr_en && (wr_addr == 2'd3);
    assign one_v = {{(NCH-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else     run <= irq_pulse ? run + 1 : '0;
    end

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (run < PULSE_CYC));

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_level && !clr_w) |=> irq_level);

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_w |=> (!irq_level && !first_vld));

    // R7
    first_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (first_vld && !clr_w) |=> (first_vld && $stable(first_idx)));

    // R4
    first_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(first_vld) |-> !(|($past(mask_q) & (one_v << first_idx))));

    // R7
    first_range_chk: assert property (@(posedge clk) disable iff (rst)
        first_vld |-> (first_idx < NCH));
endmodule

bind irq_capture_top irq_capture_chk #(.NCH(NCH), .PULSE_CYC(PULSE_CYC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irq_level (irq_level),
    .irq_pulse (irq_pulse),
    .first_vld (first_vld),
    .first_idx (first_idx),
    .mask_q    (mask_q)
);

// File: tb/irq_capture_top_tb_top.sv
module irq_capture_top_tb_top;
    localparam int NCH = 16;
    localparam int RW  = 16;

    localparam int K_LVL = 0;
    localparam int K_PUL = 1;
    localparam int K_RD  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NCH-1:0] comp_in = '1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = 2'd3;
    logic [RW-1:0] rd_data;
    logic          irq_level;
    logic          irq_pulse;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int          due;
        int          kind;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];

    irq_capture_top #(.NCH(NCH), .DB_W(16), .REG_W(RW), .PULSE_CYC(25)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .comp_in   (comp_in),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq_level (irq_level),
        .irq_pulse (irq_pulse)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] actual(input int kind);
        if (kind == K_LVL) return {15'd0, irq_level};
        if (kind == K_PUL) return {15'd0, irq_pulse};
        return rd_data;
    endfunction

    // Monitor: pops expected items that fall due this cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = q.size() - 1; k >= 0; k--) begin
                if (q[k].due == cyc) begin
                    checks++;
                    if (actual(q[k].kind) !== q[k].exp) begin
                        errors++;
                        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                                 q[k].req, q[k].kind, cyc, actual(q[k].kind), q[k].exp);
                    end
                    q.delete(k);
                end
            end
        end
    end

    task automatic push(input int dly, input int kind, input logic [15:0] exp, input string req);
        item_t it;
        it.due  = cyc + dly;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick(1);
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R10 reset state
        push(0, K_LVL, 16'h0, "R10");
        push(0, K_PUL, 16'h0, "R10");
        push(0, K_RD,  16'h0, "R10");
        tick(1);
        rd_addr = 2'd2;
        push(0, K_RD, 16'hFFFF, "R4");
        tick(1);

        // Configure: debounce 3, unmask 5 and 2, normal polarity
        wr(2'd0, 16'd3);
        wr(2'd2, ~16'h0024);
        wr(2'd1, 16'h0000);
        rd_addr = 2'd0;
        push(0, K_RD, 16'd3, "R10");
        tick(1);
        rd_addr = 2'd2;
        push(0, K_RD, ~16'h0024, "R10");
        tick(1);
        rd_addr = 2'd3;

        // R1 transient of exactly DEB_TIME cycles is rejected
        comp_in[5] = 1'b0;
        tick(3);
        comp_in[5] = 1'b1;
        tick(15);
        push(0, K_LVL, 16'h0, "R1");
        push(0, K_RD,  16'h0, "R1");
        tick(1);

        // R2 broken run: 3 active, 1 inactive, 3 active
        comp_in[5] = 1'b0; tick(3);
        comp_in[5] = 1'b1; tick(1);
        comp_in[5] = 1'b0; tick(3);
        comp_in[5] = 1'b1;
        tick(10);
        push(0, K_LVL, 16'h0, "R2");
        push(0, K_PUL, 16'h0, "R2");
        tick(1);

        // R1 accepted run, latency DEB_TIME+4; R6 pulse width
        comp_in[5] = 1'b0;
        push(6,  K_LVL, 16'h0,    "R1");
        push(7,  K_LVL, 16'h1,    "R1");
        push(7,  K_RD,  16'h8005, "R7");
        push(6,  K_PUL, 16'h0,    "R6");
        push(7,  K_PUL, 16'h1,    "R6");
        push(31, K_PUL, 16'h1,    "R6");
        push(32, K_PUL, 16'h0,    "R6");
        tick(40);

        // R7 later channel ignored; R5 level held
        comp_in[2] = 1'b0;
        tick(12);
        push(0, K_RD,  16'h8005, "R7");
        push(0, K_LVL, 16'h1,    "R5");
        push(0, K_PUL, 16'h0,    "R6");
        tick(1);

        // R9 clear while 2 and 5 still active; R8 lowest recaptured
        wr(2'd3, 16'h0);
        push(0, K_LVL, 16'h0,    "R9");
        push(0, K_RD,  16'h0,    "R9");
        push(1, K_LVL, 16'h1,    "R9");
        push(1, K_RD,  16'h8002, "R8");
        push(1, K_PUL, 16'h0,    "R9");
        push(3, K_PUL, 16'h0,    "R9");
        tick(5);

        comp_in = '1;
        tick(10);
        wr(2'd3, 16'h0);
        tick(1);
        push(0, K_LVL, 16'h0, "R9");
        push(0, K_RD,  16'h0, "R9");
        tick(1);

        // R4 masked channel has no effect
        comp_in[9] = 1'b0;
        tick(12);
        push(0, K_LVL, 16'h0, "R4");
        push(0, K_RD,  16'h0, "R4");
        push(0, K_PUL, 16'h0, "R4");
        tick(1);
        comp_in[9] = 1'b1;

        // R8 simultaneous channels 10 and 12, debounce 0
        wr(2'd0, 16'd0);
        wr(2'd2, ~16'h1400);
        comp_in[10] = 1'b0;
        comp_in[12] = 1'b0;
        push(3,  K_LVL, 16'h0,    "R1");
        push(4,  K_LVL, 16'h1,    "R1");
        push(4,  K_RD,  16'h800A, "R8");
        push(4,  K_PUL, 16'h1,    "R6");
        push(28, K_PUL, 16'h1,    "R6");
        push(29, K_PUL, 16'h0,    "R6");
        tick(35);
        comp_in = '1;
        tick(5);
        wr(2'd3, 16'h0);
        tick(2);

        // R3 inverted channel 7: low is idle, high is active
        comp_in[7] = 1'b0;
        tick(4);
        wr(2'd1, 16'h0080);
        wr(2'd2, ~16'h0080);
        tick(10);
        push(0, K_LVL, 16'h0, "R3");
        push(0, K_RD,  16'h0, "R3");
        tick(1);
        comp_in[7] = 1'b1;
        push(3, K_LVL, 16'h0,    "R3");
        push(4, K_LVL, 16'h1,    "R3");
        push(4, K_RD,  16'h8007, "R3");
        tick(10);
        comp_in[7] = 1'b0;
        tick(5);
        wr(2'd3, 16'h0);
        tick(2);
        push(0, K_LVL, 16'h0, "R9");
        tick(3);

        if (q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule